// File: doc/BRIEF.md
# Registered-Input Synchronous Dual-Port Memory

This block is a two-port static memory of 4096 words of 9 bits. Both ports can read or write the shared array on the same clock edge. On each port, the address, the write data and the control lines are captured in input registers on the rising clock edge. The ninth data bit is stored as ordinary data, so a user can keep a parity bit there if it is needed.

Each port has four active-low or select controls: a chip select, a read/write select, a clock enable and an output enable. The clock enable freezes the port's address and write-data registers, so a held cycle works on the word captured earlier. The output enable acts without the clock. The high-impedance state of a real pin is modelled by a valid flag; the data lines read zero whenever that flag is low. When both ports touch the same word on one edge, a read returns the old contents and port B's write has priority.

Top module: `dpram_dual_sync`

## Requirements
- R1: After reset, a port's read output stays invalid (rvalid 0, rdata 0) until that port has sampled cke_n low at least once. Any read or write command issued before that is ignored.
- R2: At a rising edge with cke_n low, the port captures address and write data. With cke_n high it keeps the earlier captured address and data, and that edge's read or write uses them.
- R3: cs_n low with rd_wr_n low (0 = write) at a rising edge stores the captured data at the captured address. A read issued at the next edge returns it.
- R4: cs_n low with rd_wr_n high (1 = read) at a rising edge makes rdata show the word at the captured address after that edge, with rvalid high while oe_n is low.
- R5: After an edge with cs_n high, the port's rvalid is 0 and rdata is 0, whatever the other inputs are.
- R6: oe_n high forces rvalid 0 and rdata 0 at once, without a clock edge. oe_n low brings the registered read word back at once.
- R7: After a write edge, the writing port's rvalid is 0.
- R8: When one port reads a word on the same edge that the other port writes it, the read returns the old contents. The next read edge returns the new value.
- R9: When both ports write the same word on one edge, the word holds port B's data afterwards.
- R10: All 9 data bits are stored and returned independently (0x1FF and 0x100 read back unchanged).
- R11: The two ports work at the same time on different words: a write on one port and a read on the other, both on one edge, each complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the port registers |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 9 | Port A write data |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_rd_wr_n | input | 1 | Port A direction: 1 read, 0 write |
| a_cke_n | input | 1 | Port A clock enable for address/data registers, active low |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_rdata | output | 9 | Port A read data, zero while not valid |
| a_rvalid | output | 1 | Port A output-driven flag (low models high impedance) |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 9 | Port B write data |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_rd_wr_n | input | 1 | Port B direction: 1 read, 0 write |
| b_cke_n | input | 1 | Port B clock enable for address/data registers, active low |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_rdata | output | 9 | Port B read data, zero while not valid |
| b_rvalid | output | 1 | Port B output-driven flag (low models high impedance) |

## Verification
The core store-and-fetch path is tried four ways. Single-port write-then-read shows that the data path and the address registers work. Held cycles with the address lines changed show whether the clock enable really freezes the captured address and data. Same-word traffic from both ports on one edge separates read-before-write ordering from write priority. A long random mix over sixteen words, with random select, direction, hold and output-enable values, exposes wrong interactions between these controls that the directed cases miss.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  localparam int unsigned NPORT = 2;

  // a command is accepted only once the port's registers have been loaded
  function automatic logic cmd_write(input logic cs_n, input logic rd_wr_n,
                                     input logic loaded);
    return !cs_n && !rd_wr_n && loaded;
  endfunction

  function automatic logic cmd_read(input logic cs_n, input logic rd_wr_n,
                                    input logic loaded);
    return !cs_n && rd_wr_n && loaded;
  endfunction

endpackage

// File: rtl/dpram_port_in.sv
module dpram_port_in
  import dpram_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          cs_n,
  input  logic          rd_wr_n,
  input  logic          cke_n,
  output logic [AW-1:0] eff_addr,
  output logic [DW-1:0] eff_data,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          loaded
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          loaded_q;
  logic          loaded_nx;

  assign loaded_nx = loaded_q | ~cke_n;
  assign eff_addr  = cke_n ? addr_q : addr;
  assign eff_data  = cke_n ? data_q : wdata;
  assign wr_fire   = cmd_write(cs_n, rd_wr_n, loaded_nx);
  assign rd_fire   = cmd_read(cs_n, rd_wr_n, loaded_nx);
  assign loaded    = loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      data_q   <= '0;
      loaded_q <= 1'b0;
    end else if (!cke_n) begin
      addr_q   <= addr;
      data_q   <= wdata;
      loaded_q <= 1'b1;
    end
  end

  AST_HOLD_FREEZES_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(addr_q) && $stable(data_q))); // R2
  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> loaded_q); // R1

endmodule

// File: rtl/dpram_array.sv
module dpram_array #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_data,
  input  logic          b_we,
  input  logic          b_re,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          same_word_ww;

  assign same_word_ww = a_we && b_we && (a_addr == b_addr);

  // port B's write follows port A's, so B wins on a shared word
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_data;
    if (b_we) mem[b_addr] <= b_data;
  end

  // reads see the array before this edge's writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_re) a_q <= mem[a_addr];
      if (b_re) b_q <= mem[b_addr];
    end
  end

  AST_B_WINS_SHARED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    same_word_ww |=> (mem[$past(b_addr)] == $past(b_data))); // R9
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && !(b_we && b_addr == a_addr)) |=> (mem[$past(a_addr)] == $past(a_data))); // R3

endmodule

// File: rtl/dpram_out_stage.sv
module dpram_out_stage #(
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic [DW-1:0] q,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= rd_fire;
  end

  // output enable bypasses the clock entirely
  assign rvalid = sel_q & ~oe_n;
  assign rdata  = rvalid ? q : '0;

endmodule

// File: rtl/dpram_dual_sync.sv
module dpram_dual_sync
  import dpram_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          a_cs_n,
  input  logic          a_rd_wr_n,
  input  logic          a_cke_n,
  input  logic          a_oe_n,
  output logic [DW-1:0] a_rdata,
  output logic          a_rvalid,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  input  logic          b_cs_n,
  input  logic          b_rd_wr_n,
  input  logic          b_cke_n,
  input  logic          b_oe_n,
  output logic [DW-1:0] b_rdata,
  output logic          b_rvalid
);

  logic [AW-1:0] in_addr  [NPORT];
  logic [DW-1:0] in_data  [NPORT];
  logic          in_cs_n  [NPORT];
  logic          in_rw    [NPORT];
  logic          in_cke_n [NPORT];
  logic          in_oe_n  [NPORT];
  logic [AW-1:0] eff_addr [NPORT];
  logic [DW-1:0] eff_data [NPORT];
  logic          wr_fire  [NPORT];
  logic          rd_fire  [NPORT];
  logic          loaded   [NPORT];
  logic [DW-1:0] arr_q    [NPORT];
  logic [DW-1:0] out_data [NPORT];
  logic          out_vld  [NPORT];

  assign in_addr[0] = a_addr;    assign in_addr[1] = b_addr;
  assign in_data[0] = a_wdata;   assign in_data[1] = b_wdata;
  assign in_cs_n[0] = a_cs_n;    assign in_cs_n[1] = b_cs_n;
  assign in_rw[0]   = a_rd_wr_n; assign in_rw[1]   = b_rd_wr_n;
  assign in_cke_n[0] = a_cke_n;  assign in_cke_n[1] = b_cke_n;
  assign in_oe_n[0] = a_oe_n;    assign in_oe_n[1] = b_oe_n;

  assign a_rdata  = out_data[0];
  assign a_rvalid = out_vld[0];
  assign b_rdata  = out_data[1];
  assign b_rvalid = out_vld[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpram_port_in #(.AW(AW), .DW(DW)) u_in (
      .clk(clk), .rst_n(rst_n),
      .addr(in_addr[p]), .wdata(in_data[p]),
      .cs_n(in_cs_n[p]), .rd_wr_n(in_rw[p]), .cke_n(in_cke_n[p]),
      .eff_addr(eff_addr[p]), .eff_data(eff_data[p]),
      .wr_fire(wr_fire[p]), .rd_fire(rd_fire[p]), .loaded(loaded[p])
    );

    dpram_out_stage #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n),
      .rd_fire(rd_fire[p]), .q(arr_q[p]), .oe_n(in_oe_n[p]),
      .rdata(out_data[p]), .rvalid(out_vld[p])
    );

    AST_UNLOADED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !loaded[p] |-> !out_vld[p]); // R1
    AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_cs_n[p]) |-> (!out_vld[p] && out_data[p] == '0)); // R5
    AST_WRITE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!in_cs_n[p] && !in_rw[p]) |-> !out_vld[p]); // R7
    AST_OE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      in_oe_n[p] |-> (!out_vld[p] && out_data[p] == '0)); // R6
  end

  dpram_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .a_addr(eff_addr[0]), .a_data(eff_data[0]), .a_we(wr_fire[0]), .a_re(rd_fire[0]),
    .b_addr(eff_addr[1]), .b_data(eff_data[1]), .b_we(wr_fire[1]), .b_re(rd_fire[1]),
    .a_q(arr_q[0]), .b_q(arr_q[1])
  );

endmodule

// File: tb/tb_dpram_dual_sync.sv
`timescale 1ns/1ps
module tb_dpram_dual_sync;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] p_addr [2];
  logic [8:0]  p_wd   [2];
  logic        p_cs   [2];
  logic        p_rw   [2];
  logic        p_cke  [2];
  logic        p_oe   [2];
  logic [8:0]  p_rd   [2];
  logic        p_rv   [2];

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [8:0]  ref_mem [int];
  bit          m_load [2];
  logic [11:0] m_addr [2];
  logic [8:0]  m_data [2];
  bit          m_sel  [2];
  logic [8:0]  m_q    [2];

  always #2.5 clk = ~clk;

  dpram_dual_sync dut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(p_addr[0]), .a_wdata(p_wd[0]), .a_cs_n(p_cs[0]), .a_rd_wr_n(p_rw[0]),
    .a_cke_n(p_cke[0]), .a_oe_n(p_oe[0]), .a_rdata(p_rd[0]), .a_rvalid(p_rv[0]),
    .b_addr(p_addr[1]), .b_wdata(p_wd[1]), .b_cs_n(p_cs[1]), .b_rd_wr_n(p_rw[1]),
    .b_cke_n(p_cke[1]), .b_oe_n(p_oe[1]), .b_rdata(p_rd[1]), .b_rvalid(p_rv[1])
  );

  task automatic compare_now(input string tag);
    for (int p = 0; p < 2; p++) begin
      logic       ev;
      logic [8:0] ed;
      ev = m_sel[p] && !p_oe[p];
      ed = ev ? m_q[p] : 9'h000;
      checks++;
      if (p_rv[p] !== ev || p_rd[p] !== ed) begin
        failures++;
        $display("FAIL %s port%0d: rvalid=%0b rdata=%03h expected rvalid=%0b rdata=%03h",
                 tag, p, p_rv[p], p_rd[p], ev, ed);
      end
    end
  endtask

  // one clock: model update at the edge, compare just after it
  task automatic cyc();
    bit          nl [2];
    logic [11:0] ea [2];
    logic [8:0]  ed [2];
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      nl[p] = m_load[p] || !p_cke[p];
      ea[p] = p_cke[p] ? m_addr[p] : p_addr[p];
      ed[p] = p_cke[p] ? m_data[p] : p_wd[p];
    end
    for (int p = 0; p < 2; p++) begin
      m_sel[p] = !p_cs[p] && p_rw[p] && nl[p];
      if (m_sel[p]) m_q[p] = ref_mem.exists(int'(ea[p])) ? ref_mem[int'(ea[p])] : 9'h000;
    end
    for (int p = 0; p < 2; p++)
      if (!p_cs[p] && !p_rw[p] && nl[p]) ref_mem[int'(ea[p])] = ed[p];
    for (int p = 0; p < 2; p++) begin
      m_load[p] = nl[p];
      m_addr[p] = ea[p];
      m_data[p] = ed[p];
    end
    #1;
    compare_now(cur_req);
    @(negedge clk);
  endtask

  task automatic idle(input int p);
    p_cs[p] = 1'b1; p_rw[p] = 1'b1; p_cke[p] = 1'b0;
  endtask

  task automatic wr(input int p, input int a, input int d);
    p_cs[p] = 1'b0; p_rw[p] = 1'b0; p_cke[p] = 1'b0;
    p_addr[p] = 12'(a); p_wd[p] = 9'(d);
  endtask

  task automatic rd(input int p, input int a);
    p_cs[p] = 1'b0; p_rw[p] = 1'b1; p_cke[p] = 1'b0; p_addr[p] = 12'(a);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      p_addr[p] = '0; p_wd[p] = '0; p_cs[p] = 1'b1; p_rw[p] = 1'b1;
      p_cke[p] = 1'b1; p_oe[p] = 1'b0;
      m_load[p] = 0; m_addr[p] = '0; m_data[p] = '0; m_sel[p] = 0; m_q[p] = '0;
    end
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare_now("R1");            // reset state
    rst_n = 1'b1;
    @(negedge clk);
    // R1: commands with cke_n held high before any load are ignored
    for (int p = 0; p < 2; p++) begin p_cs[p] = 1'b0; p_rw[p] = 1'b1; p_cke[p] = 1'b1; end
    cyc(); cyc();

    cur_req = "R3";
    wr(0, 5, 'h0AB); idle(1); cyc();
    rd(0, 5); cyc();
    cur_req = "R7";
    wr(1, 6, 'h07E); cyc();
    cur_req = "R10";
    wr(0, 7, 'h1FF); wr(1, 8, 'h100); cyc();
    rd(0, 8); rd(1, 7); cyc();

    cur_req = "R2";
    wr(0, 11, 'h033); idle(1); cyc();
    wr(0, 10, 'h055); cyc();
    p_cke[0] = 1'b1; p_addr[0] = 12'd11; p_wd[0] = 9'h0EE; cyc();   // held write to 10
    rd(0, 11); cyc();
    p_cke[0] = 1'b1; p_addr[0] = 12'd5; cyc();                      // held read of 11
    rd(0, 10); cyc();

    cur_req = "R4";
    rd(0, 7); rd(1, 5); cyc();
    cur_req = "R6";
    p_oe[0] = 1'b1; #1; compare_now("R6");
    p_oe[0] = 1'b0; #1; compare_now("R6");
    p_oe[1] = 1'b1; cyc();
    p_oe[1] = 1'b0; #1; compare_now("R6");
    @(negedge clk);

    cur_req = "R5";
    idle(0); p_rw[0] = 1'b1; p_oe[0] = 1'b0; cyc();
    idle(1); p_cke[1] = 1'b1; cyc();

    cur_req = "R8";
    wr(0, 20, 'h010); idle(1); cyc();
    rd(0, 20); wr(1, 20, 'h1A5); cyc();
    rd(0, 20); idle(1); cyc();

    cur_req = "R9";
    wr(0, 30, 'h0C3); wr(1, 30, 'h13C); cyc();
    rd(0, 30); rd(1, 30); cyc();

    cur_req = "R11";
    wr(0, 40, 'h111); rd(1, 5); cyc();
    rd(0, 6); wr(1, 41, 'h022); cyc();
    rd(0, 41); rd(1, 40); cyc();

    cur_req = "R4";
    for (int a = 0; a < 16; a++) begin wr(0, a, a * 29); idle(1); cyc(); end
    for (int i = 0; i < 400; i++) begin
      for (int p = 0; p < 2; p++) begin
        p_cs[p]   = ($urandom % 4) == 0;
        p_rw[p]   = $urandom % 2;
        p_cke[p]  = ($urandom % 3) == 0;
        p_oe[p]   = ($urandom % 5) == 0;
        p_addr[p] = 12'($urandom % 16);
        p_wd[p]   = 9'($urandom);
      end
      cyc();
    end

    finish_run();
  end

endmodule